// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank

This block holds the configuration of a display pipeline that draws several overlaid windows. Every software write lands in a pending copy. The working copies that feed the pipeline are loaded from the pending copies only when the vertical sync strobe arrives. A configuration change therefore never takes effect in the middle of a frame.

Each window carries a hold bit. While a window's hold bit is set, that window keeps its working values across any number of sync strobes. Software can set the hold bit, rewrite the window's position, size, control and key registers, and then clear the bit. The whole change then reaches the pipeline at the next sync as one step. Video output needs two things: an enable bit that acts at once, and a second enable bit that is latched at the frame boundary.

Window 0 has no key/alpha register. A read returns the pending copy. A parallel debug read returns the working copy at the same address.

Top module: `shadow_bank`

## Requirements
- R1: A write changes only the pending copy. Every working output (`win_ctrl_o`, `win_pos_o`, `win_size_o`, `win_key_o`) stays unchanged in every cycle where `vsync_i` is low.
- R2: In a cycle where `vsync_i` is high, each window whose hold bit is clear gets all four working registers loaded from its pending values. In the same cycle the frame-latched run bit gets ctrl bit 1.
- R3: A window whose hold bit (address 0x01, bit w for window w) is set keeps its working values across a sync strobe. Other windows still update at that strobe.
- R4: The hold register acts on the cycle after it is written. A sync in the same cycle as a hold write is judged against the old hold value. After a window's hold bit is cleared, its pending values reach the working copy at the next sync.
- R5: Register 0x00 holds bit 0, an immediate run bit, and bit 1, a frame-latched run bit. `video_on_o` is high exactly when bit 0 of the pending copy and the latched copy of bit 1 are both set. Clearing bit 0 stops video on the next cycle, with no sync needed.
- R6: When a write and a sync fall in the same cycle, the pending copy takes the new data. The working copy takes the pending value from before the write.
- R7: Window w occupies addresses 0x10+4w to 0x13+4w, in this order: control, position, size, key. The window control register keeps bits 7:0: bit 0 window enable, bit 1 channel enable, bits 7:4 pixel format. Window 0's key address (0x13) ignores writes, reads as 0, and its working key output stays 0.
- R8: After reset every pending copy, working copy and hold bit is zero, and `video_on_o` is low.
- R9: `rdata_o` returns the pending value at `addr_i`. `dbg_rdata_o` returns the working value there. At 0x00 it returns {latched bit 1, pending bit 0}, and at 0x01 it returns the hold bits.
- R10: Writes to unmapped addresses have no effect. Reads from unmapped addresses return 0 on both read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for write and both reads |
| wdata_i | input | DATA_W | Write data |
| vsync_i | input | 1 | One-cycle frame-boundary strobe |
| rdata_o | output | DATA_W | Pending value at addr_i |
| dbg_rdata_o | output | DATA_W | Working value at addr_i |
| video_on_o | output | 1 | Video output enabled |
| win_ctrl_o | output | NUM_WIN*CTRL_W | Working window control, window w at slice w |
| win_pos_o | output | NUM_WIN*DATA_W | Working window position |
| win_size_o | output | NUM_WIN*DATA_W | Working window size |
| win_key_o | output | NUM_WIN*DATA_W | Working window key/alpha (zero for window 0) |

## Verification
Two pairs of events can meet in the same clock edge. The first is a register write and the sync strobe. The second is a hold-bit write and the sync strobe. The bench places each collision on purpose: a write to a window register together with `vsync_i`, and a hold write together with `vsync_i`. A long pseudo-random run then mixes writes, holds and strobes so these collisions also occur freely. A behavioural model in the bench decides each edge by the rule "transfer with the old pending and old hold, then apply the write". It compares every output, including both read ports, on every cycle.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

    // Register layout inside one window's block of addresses.
    localparam int unsigned REG_PER_WIN = 4;
    localparam int unsigned IDX_CTRL    = 0;
    localparam int unsigned IDX_POS     = 1;
    localparam int unsigned IDX_SIZE    = 2;
    localparam int unsigned IDX_KEY     = 3;

    // Global register addresses and first window address.
    localparam int unsigned ADDR_RUN    = 0;
    localparam int unsigned ADDR_HOLD   = 1;
    localparam int unsigned WIN_BASE    = 16;

    // Per-window latch state.
    typedef enum logic [1:0] {
        WS_CLEAN = 2'd0,   // working equals pending
        WS_DIRTY = 2'd1,   // pending written, waiting for sync
        WS_HELD  = 2'd2    // hold bit set, transfers blocked
    } win_state_e;

    // Video run state.
    typedef enum logic [1:0] {
        RUN_OFF   = 2'd0,
        RUN_ARMED = 2'd1,  // one of the two run bits set
        RUN_ON    = 2'd2   // immediate bit and latched bit both set
    } run_state_e;

endpackage

// File: rtl/shadow_win.sv
module shadow_win
    import shadow_bank_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CTRL_W  = 8,
    parameter bit          HAS_KEY = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [1:0]        idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              vsync_i,
    input  logic              hold_i,
    output logic [CTRL_W-1:0] pend_ctrl_o,
    output logic [CTRL_W-1:0] work_ctrl_o,
    output logic [DATA_W-1:0] pend_pos_o,
    output logic [DATA_W-1:0] work_pos_o,
    output logic [DATA_W-1:0] pend_size_o,
    output logic [DATA_W-1:0] work_size_o,
    output logic [DATA_W-1:0] pend_key_o,
    output logic [DATA_W-1:0] work_key_o
);

    win_state_e state_q, state_d;
    logic       load_en;
    logic       wr_ctrl, wr_pos, wr_size;

    assign wr_ctrl = wr_i && (idx_i == 2'(IDX_CTRL));
    assign wr_pos  = wr_i && (idx_i == 2'(IDX_POS));
    assign wr_size = wr_i && (idx_i == 2'(IDX_SIZE));

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= WS_CLEAN;
        else         state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_CLEAN: begin
                if (hold_i)    state_d = WS_HELD;
                else if (wr_i) state_d = WS_DIRTY;
            end
            WS_DIRTY: begin
                if (hold_i)                state_d = WS_HELD;
                else if (vsync_i && !wr_i) state_d = WS_CLEAN;
            end
            WS_HELD: begin
                if (!hold_i) state_d = (vsync_i && !wr_i) ? WS_CLEAN : WS_DIRTY;
            end
            default: state_d = WS_DIRTY;
        endcase
    end

    // Outputs of the state machine.
    always_comb begin
        load_en = 1'b0;
        unique case (state_q)
            WS_CLEAN:         load_en = 1'b0;
            WS_DIRTY, WS_HELD: load_en = vsync_i && !hold_i;
            default:          load_en = vsync_i && !hold_i;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_ctrl_o <= '0;
            pend_pos_o  <= '0;
            pend_size_o <= '0;
            work_ctrl_o <= '0;
            work_pos_o  <= '0;
            work_size_o <= '0;
        end else begin
            if (load_en) begin
                work_ctrl_o <= pend_ctrl_o;
                work_pos_o  <= pend_pos_o;
                work_size_o <= pend_size_o;
            end
            if (wr_ctrl) pend_ctrl_o <= wdata_i[CTRL_W-1:0];
            if (wr_pos)  pend_pos_o  <= wdata_i;
            if (wr_size) pend_size_o <= wdata_i;
        end
    end

    generate
        if (HAS_KEY) begin : g_key
            logic wr_key;
            assign wr_key = wr_i && (idx_i == 2'(IDX_KEY));
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    pend_key_o <= '0;
                    work_key_o <= '0;
                end else begin
                    if (load_en) work_key_o <= pend_key_o;
                    if (wr_key)  pend_key_o <= wdata_i;
                end
            end
        end else begin : g_nokey
            assign pend_key_o = '0;
            assign work_key_o = '0;
        end
    endgenerate

endmodule

// File: rtl/shadow_glob.sv
module shadow_glob
    import shadow_bank_pkg::*;
#(
    parameter int unsigned NUM_WIN = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_run_i,
    input  logic               wr_hold_i,
    input  logic [1:0]         run_wdata_i,
    input  logic [NUM_WIN-1:0] hold_wdata_i,
    input  logic               vsync_i,
    output logic [1:0]         run_pend_o,
    output logic               run_frame_o,
    output logic [NUM_WIN-1:0] hold_o,
    output logic               video_on_o
);

    run_state_e state_q, state_d;
    logic [1:0] run_pend_d;
    logic       run_frame_d;

    assign run_pend_d  = wr_run_i ? run_wdata_i : run_pend_o;
    assign run_frame_d = vsync_i ? run_pend_o[1] : run_frame_o;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_pend_o  <= '0;
            run_frame_o <= 1'b0;
            hold_o      <= '0;
        end else begin
            run_pend_o  <= run_pend_d;
            run_frame_o <= run_frame_d;
            if (wr_hold_i) hold_o <= hold_wdata_i;
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= RUN_OFF;
        else         state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_OFF, RUN_ARMED: begin
                if (run_pend_d[0] && run_frame_d)      state_d = RUN_ON;
                else if (run_pend_d[0] || run_frame_d) state_d = RUN_ARMED;
                else                                   state_d = RUN_OFF;
            end
            RUN_ON: begin
                if (!(run_pend_d[0] && run_frame_d))
                    state_d = (run_pend_d[0] || run_frame_d) ? RUN_ARMED : RUN_OFF;
            end
            default: state_d = RUN_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        video_on_o = 1'b0;
        unique case (state_q)
            RUN_ON:             video_on_o = 1'b1;
            RUN_OFF, RUN_ARMED: video_on_o = 1'b0;
            default:            video_on_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import shadow_bank_pkg::*;
#(
    parameter int unsigned NUM_WIN = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic                      vsync_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [DATA_W-1:0]         dbg_rdata_o,
    output logic                      video_on_o,
    output logic [NUM_WIN*CTRL_W-1:0] win_ctrl_o,
    output logic [NUM_WIN*DATA_W-1:0] win_pos_o,
    output logic [NUM_WIN*DATA_W-1:0] win_size_o,
    output logic [NUM_WIN*DATA_W-1:0] win_key_o
);

    localparam int unsigned BLK_W     = ADDR_W - 2;
    localparam int unsigned FIRST_BLK = WIN_BASE / REG_PER_WIN;

    logic [1:0]         run_pend;
    logic               run_frame;
    logic [NUM_WIN-1:0] hold_q;
    logic               wr_run, wr_hold;

    logic [CTRL_W-1:0] pend_ctrl [NUM_WIN];
    logic [CTRL_W-1:0] work_ctrl [NUM_WIN];
    logic [DATA_W-1:0] pend_pos  [NUM_WIN];
    logic [DATA_W-1:0] work_pos  [NUM_WIN];
    logic [DATA_W-1:0] pend_size [NUM_WIN];
    logic [DATA_W-1:0] work_size [NUM_WIN];
    logic [DATA_W-1:0] pend_key  [NUM_WIN];
    logic [DATA_W-1:0] work_key  [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    logic [NUM_WIN*DATA_W-1:0] pend_pos_flat;

    assign wr_run  = wr_en_i && (addr_i == ADDR_W'(ADDR_RUN));
    assign wr_hold = wr_en_i && (addr_i == ADDR_W'(ADDR_HOLD));

    shadow_glob #(.NUM_WIN(NUM_WIN)) u_glob (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_run_i     (wr_run),
        .wr_hold_i    (wr_hold),
        .run_wdata_i  (wdata_i[1:0]),
        .hold_wdata_i (wdata_i[NUM_WIN-1:0]),
        .vsync_i      (vsync_i),
        .run_pend_o   (run_pend),
        .run_frame_o  (run_frame),
        .hold_o       (hold_q),
        .video_on_o   (video_on_o)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            assign win_hit[w] = (addr_i[ADDR_W-1:2] == BLK_W'(FIRST_BLK + w));

            shadow_win #(
                .DATA_W  (DATA_W),
                .CTRL_W  (CTRL_W),
                .HAS_KEY (w != 0)
            ) u_win (
                .clk_i       (clk_i),
                .rst_ni      (rst_ni),
                .wr_i        (wr_en_i && win_hit[w]),
                .idx_i       (addr_i[1:0]),
                .wdata_i     (wdata_i),
                .vsync_i     (vsync_i),
                .hold_i      (hold_q[w]),
                .pend_ctrl_o (pend_ctrl[w]),
                .work_ctrl_o (work_ctrl[w]),
                .pend_pos_o  (pend_pos[w]),
                .work_pos_o  (work_pos[w]),
                .pend_size_o (pend_size[w]),
                .work_size_o (work_size[w]),
                .pend_key_o  (pend_key[w]),
                .work_key_o  (work_key[w])
            );

            assign win_ctrl_o[w*CTRL_W +: CTRL_W]    = work_ctrl[w];
            assign win_pos_o[w*DATA_W +: DATA_W]     = work_pos[w];
            assign win_size_o[w*DATA_W +: DATA_W]    = work_size[w];
            assign win_key_o[w*DATA_W +: DATA_W]     = work_key[w];
            assign pend_pos_flat[w*DATA_W +: DATA_W] = pend_pos[w];
        end
    endgenerate

    // Read ports: pending view and working view.
    always_comb begin
        rdata_o     = '0;
        dbg_rdata_o = '0;
        if (addr_i == ADDR_W'(ADDR_RUN)) begin
            rdata_o     = DATA_W'(run_pend);
            dbg_rdata_o = DATA_W'({run_frame, run_pend[0]});
        end else if (addr_i == ADDR_W'(ADDR_HOLD)) begin
            rdata_o     = DATA_W'(hold_q);
            dbg_rdata_o = DATA_W'(hold_q);
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (win_hit[w]) begin
                    unique case (addr_i[1:0])
                        2'(IDX_CTRL): begin
                            rdata_o     = DATA_W'(pend_ctrl[w]);
                            dbg_rdata_o = DATA_W'(work_ctrl[w]);
                        end
                        2'(IDX_POS): begin
                            rdata_o     = pend_pos[w];
                            dbg_rdata_o = work_pos[w];
                        end
                        2'(IDX_SIZE): begin
                            rdata_o     = pend_size[w];
                            dbg_rdata_o = work_size[w];
                        end
                        default: begin
                            rdata_o     = pend_key[w];
                            dbg_rdata_o = work_key[w];
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
    parameter int unsigned NUM_WIN = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned ADDR_W  = 8
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      wr_en_i,
    input logic [ADDR_W-1:0]         addr_i,
    input logic                      vsync_i,
    input logic                      video_on_o,
    input logic [NUM_WIN-1:0]        hold_q,
    input logic [NUM_WIN*DATA_W-1:0] pend_pos_flat,
    input logic [NUM_WIN*CTRL_W-1:0] win_ctrl_o,
    input logic [NUM_WIN*DATA_W-1:0] win_pos_o,
    input logic [NUM_WIN*DATA_W-1:0] win_size_o,
    input logic [NUM_WIN*DATA_W-1:0] win_key_o
);

    // R1: no working output moves without a sync strobe.
    assert_stable_no_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vsync_i |=> ($stable(win_ctrl_o) && $stable(win_pos_o) &&
                      $stable(win_size_o) && $stable(win_key_o)));

    // R5: video can only start at a sync or a run-register write.
    assert_video_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(video_on_o) |-> $past(vsync_i || (wr_en_i && addr_i == '0)));

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
            // R3: a held window ignores the sync strobe.
            assert_held_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (vsync_i && hold_q[w]) |=>
                    ($stable(win_pos_o[w*DATA_W +: DATA_W]) &&
                     $stable(win_ctrl_o[w*CTRL_W +: CTRL_W])));

            // R2: a free window takes the pending position at the sync.
            assert_sync_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (vsync_i && !hold_q[w]) |=>
                    (win_pos_o[w*DATA_W +: DATA_W] == $past(pend_pos_flat[w*DATA_W +: DATA_W])));
        end
    endgenerate

endmodule

bind shadow_bank shadow_bank_chk #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W),
    .CTRL_W  (CTRL_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .addr_i        (addr_i),
    .vsync_i       (vsync_i),
    .video_on_o    (video_on_o),
    .hold_q        (hold_q),
    .pend_pos_flat (pend_pos_flat),
    .win_ctrl_o    (win_ctrl_o),
    .win_pos_o     (win_pos_o),
    .win_size_o    (win_size_o),
    .win_key_o     (win_key_o)
);

// File: tb/tb_shadow_bank.sv
module tb_shadow_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 5;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          vsync = 1'b0;
    logic [DW-1:0] rdata, dbg_rdata;
    logic          video_on;
    logic [NW*CW-1:0] win_ctrl;
    logic [NW*DW-1:0] win_pos, win_size, win_key;

    int checks = 0;
    int failures = 0;

    // Behavioural model: pending and working images indexed by address.
    logic [31:0] pm [256];
    logic [31:0] wm [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_bank dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .vsync_i     (vsync),
        .rdata_o     (rdata),
        .dbg_rdata_o (dbg_rdata),
        .video_on_o  (video_on),
        .win_ctrl_o  (win_ctrl),
        .win_pos_o   (win_pos),
        .win_size_o  (win_size),
        .win_key_o   (win_key)
    );

    function automatic bit mapped(input logic [7:0] a);
        return (a == 8'd0) || (a == 8'd1) ||
               (a >= 8'd16 && a < 8'(16 + 4*NW) && a != 8'd19);
    endfunction

    function automatic logic [31:0] wmask(input logic [7:0] a);
        if (a == 8'd0) return 32'h3;
        if (a == 8'd1) return 32'h1f;
        if (a[1:0] == 2'd0) return 32'hff;
        return 32'hffff_ffff;
    endfunction

    task automatic model_edge(input logic wr, input logic [7:0] a,
                              input logic [31:0] d, input logic vs);
        logic [31:0] old_hold;
        old_hold = pm[1];
        if (vs) begin
            wm[0] = pm[0];
            for (int w = 0; w < NW; w++)
                if (!old_hold[w])
                    for (int i = 0; i < 4; i++) wm[16+4*w+i] = pm[16+4*w+i];
        end
        if (wr && mapped(a)) pm[a] = d & wmask(a);
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                       input string tag, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [31:0] er, ed;
        chk(32'(video_on), 32'(pm[0][0] & wm[0][1]), tag, "video_on");
        for (int w = 0; w < NW; w++) begin
            chk(32'(win_ctrl[w*CW +: CW]), wm[16+4*w] & 32'hff, tag, $sformatf("ctrl w%0d", w));
            chk(win_pos[w*DW +: DW],  wm[17+4*w], tag, $sformatf("pos w%0d", w));
            chk(win_size[w*DW +: DW], wm[18+4*w], tag, $sformatf("size w%0d", w));
            chk(win_key[w*DW +: DW],  wm[19+4*w], tag, $sformatf("key w%0d", w));
        end
        er = mapped(addr) ? pm[addr] : 32'h0;
        if (addr == 8'd0)      ed = {30'h0, wm[0][1], pm[0][0]};
        else if (addr == 8'd1) ed = pm[1];
        else                   ed = mapped(addr) ? wm[addr] : 32'h0;
        chk(rdata, er, tag, "rdata");
        chk(dbg_rdata, ed, tag, "dbg_rdata");
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic wr, input logic [7:0] a,
                        input logic [31:0] d, input logic vs, input string tag);
        wr_en = wr; addr = a; wdata = d; vsync = vs;
        @(posedge clk);
        model_edge(wr, a, d, vs);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 256; i++) begin pm[i] = '0; wm[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R8");

        // R1 / R9: write window 1, nothing moves before sync.
        step(1'b1, 8'd21, 32'h1234_5678, 1'b0, "R1");
        step(1'b1, 8'd22, 32'h0040_0030, 1'b0, "R1");
        step(1'b1, 8'd20, 32'h0000_0013, 1'b0, "R7");
        step(1'b0, 8'd21, 32'h0, 1'b0, "R9");
        step(1'b0, 8'd21, 32'h0, 1'b1, "R2");
        step(1'b0, 8'd22, 32'h0, 1'b0, "R2");

        // R3 / R4: hold window 2, update it and window 3.
        step(1'b1, 8'd1,  32'h0000_0004, 1'b0, "R4");
        step(1'b1, 8'd25, 32'hAAAA_0001, 1'b0, "R3");
        step(1'b1, 8'd27, 32'h00FF_00FF, 1'b0, "R3");
        step(1'b1, 8'd29, 32'hBBBB_0002, 1'b0, "R3");
        step(1'b0, 8'd25, 32'h0, 1'b1, "R3");
        step(1'b0, 8'd25, 32'h0, 1'b1, "R3");
        step(1'b1, 8'd1,  32'h0, 1'b0, "R4");
        step(1'b0, 8'd25, 32'h0, 1'b0, "R4");
        step(1'b0, 8'd25, 32'h0, 1'b1, "R4");

        // R4: hold write in the sync cycle is judged against the old hold.
        step(1'b1, 8'd33, 32'hCAFE_0004, 1'b0, "R4");
        step(1'b1, 8'd1,  32'h0000_0010, 1'b1, "R4");
        step(1'b1, 8'd33, 32'hDEAD_0004, 1'b0, "R4");
        step(1'b0, 8'd33, 32'h0, 1'b1, "R4");
        step(1'b1, 8'd1,  32'h0, 1'b0, "R4");

        // R6: write and sync in the same cycle.
        step(1'b1, 8'd29, 32'h1111_1111, 1'b0, "R6");
        step(1'b1, 8'd29, 32'h2222_2222, 1'b1, "R6");
        step(1'b0, 8'd29, 32'h0, 1'b0, "R6");
        step(1'b0, 8'd29, 32'h0, 1'b1, "R6");

        // R5: video enable bits.
        step(1'b1, 8'd0, 32'h1, 1'b0, "R5");
        step(1'b0, 8'd0, 32'h0, 1'b1, "R5");
        step(1'b1, 8'd0, 32'h3, 1'b0, "R5");
        step(1'b0, 8'd0, 32'h0, 1'b1, "R5");
        step(1'b1, 8'd0, 32'h2, 1'b0, "R5");
        step(1'b1, 8'd0, 32'h3, 1'b0, "R5");

        // R7: window 0 has no key register.
        step(1'b1, 8'd19, 32'hFFFF_FFFF, 1'b0, "R7");
        step(1'b0, 8'd19, 32'h0, 1'b1, "R7");

        // R10: unmapped addresses.
        step(1'b1, 8'd5,  32'h5555_5555, 1'b0, "R10");
        step(1'b1, 8'd48, 32'h6666_6666, 1'b1, "R10");
        step(1'b0, 8'd5,  32'h0, 1'b0, "R10");

        // Mixed traffic: writes, holds and strobes collide freely (R2, R6).
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(r[0] | r[1], 8'(r[15:8] % 40), lfsr, r[2] & r[3], "R6");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule